// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block is a first-level interrupt controller. It takes a configurable number of level-sensitive interrupt lines from on-chip peripherals and drives one interrupt output per CPU. Each output is meant to be wired to one hardware interrupt input of its CPU. No inputs can be configured for polarity or edge. A line counts as pending while it is high, and software clears it at the peripheral that raised it.

Every CPU sees its own register window containing three groups of 32-bit words: status, mask-set and mask-clear. The status words show the raw input levels. Writing ones to a mask-set word masks those lines for that CPU only, and writing ones to a mask-clear word unmasks them. Bits written as zero keep their value, so no read-modify-write is needed. Because every CPU has its own mask, a line can be steered to any subset of CPUs. The block has no priority logic and no queue: a handler reads all status words and masks of its window to find the work it has to do.

The bus is a simple single-cycle port. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low.

Top module: `irqagg_top`

## Requirements
- R1: After reset every line is masked for every CPU, every `cpu_irq` bit is low, and every mask word reads back as all ones.
- R2: A read of status word k in any CPU window returns the current levels of lines 32k..32k+31, whatever the mask.
- R3: Writing a mask-set word of CPU c sets, in c's mask, each bit written as one and leaves each bit written as zero unchanged; a mask bit of 1 means masked.
- R4: Writing a mask-clear word of CPU c clears, in c's mask, each bit written as one and leaves each bit written as zero unchanged.
- R5: A read of a mask-set word or of a mask-clear word returns the current mask of that CPU for the same 32 lines.
- R6: `cpu_irq[c]` is high in the cycle after a clock edge at which some line was high and unmasked for CPU c, and low in the cycle after an edge at which no such line existed. A mask write at edge E therefore shows on `cpu_irq` after edge E+1.
- R7: A write in the window of one CPU never changes the mask of any other CPU.
- R8: Writes to status words are ignored: no mask changes.
- R9: A read at a word offset of 3*W or above within a window, or of a CPU index at or beyond NUM_CPUS, returns zero. A write there changes nothing. A read with `bus_sel` low also returns zero.
- R10: Layout, with W = NUM_LINES/32 and S = 2^ceil(log2(12*W)) bytes. The byte address is cpu*S + 4*offset. Offsets 0..W-1 are status, W..2W-1 are mask-set and 2W..3W-1 are mask-clear. Word k, bit b stands for line 32k+b. With 128 lines, S is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | NUM_LINES | Level-sensitive peripheral interrupt lines, high = pending |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: CPU index above the window offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| cpu_irq | output | NUM_CPUS | Registered interrupt output per CPU |

## Verification
The assertions assume that the interrupt lines and the bus inputs are stable around each rising clock edge. They also assume that the word addresses are aligned, so the two low address bits are ignored. The bench changes every input only on the falling edge and drives only word-aligned addresses. The per-CPU assertions take a one-cycle history of the lines and masks as the cause of each output value. They are gated by the internally synchronised reset, which the bench releases only after several clock edges. The random stimulus also writes deliberately to status words and to out-of-range offsets, so that the cases the assertions treat as no-ops actually occur.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  typedef enum logic [1:0] {
    GRP_STAT = 2'd0,
    GRP_SET  = 2'd1,
    GRP_CLR  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  // Byte address bits spanned by one CPU window of 3*words registers.
  function automatic int win_lsb(input int words);
    return $clog2(3 * words * 4);
  endfunction

  function automatic int cpu_bits(input int cpus);
    return (cpus > 1) ? $clog2(cpus) : 1;
  endfunction

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
  import irqagg_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int WORDS    = 4,
  localparam int WLSB    = win_lsb(WORDS),
  localparam int CPU_W   = cpu_bits(NUM_CPUS),
  localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W  = CPU_W + WLSB,
  localparam int OFF_W   = WLSB - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CPU_W-1:0]  cpu,
  output grp_e              grp,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);

  logic [OFF_W-1:0] off;

  assign cpu = addr[ADDR_W-1:WLSB];
  assign off = addr[WLSB-1:2];

  always_comb begin
    grp = GRP_NONE;
    idx = '0;
    if (int'(off) < WORDS) begin
      grp = GRP_STAT;
      idx = IDX_W'(int'(off));
    end else if (int'(off) < 2 * WORDS) begin
      grp = GRP_SET;
      idx = IDX_W'(int'(off) - WORDS);
    end else if (int'(off) < 3 * WORDS) begin
      grp = GRP_CLR;
      idx = IDX_W'(int'(off) - 2 * WORDS);
    end
  end

  assign hit = (grp != GRP_NONE) && (int'(cpu) < NUM_CPUS);

endmodule

// File: rtl/irqagg_mask_bank.sv
module irqagg_mask_bank #(
  parameter int NUM_LINES = 128,
  localparam int WORDS    = NUM_LINES / 32,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic                 set_en,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [31:0]          wdata,
  output logic [NUM_LINES-1:0] mask,
  output logic                 irq
);

  logic [NUM_LINES-1:0] mask_q, mask_d;
  logic                 mask_ce;
  logic                 irq_q, irq_d;

  // Next-state: atomic set/clear on a single 32-bit word
  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d[int'(idx)*32 +: 32] = mask_q[int'(idx)*32 +: 32] | wdata;
    if (clr_en) mask_d[int'(idx)*32 +: 32] = mask_q[int'(idx)*32 +: 32] & ~wdata;
  end

  assign mask_ce = set_en | clr_en;
  assign irq_d   = |(lines & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign mask = mask_q;
  assign irq  = irq_q;

endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int NUM_CPUS  = 2,
  localparam int WORDS    = NUM_LINES / 32,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CPU_W    = cpu_bits(NUM_CPUS)
) (
  input  logic                                sel,
  input  logic                                wr,
  input  logic [NUM_LINES-1:0]                lines,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  mask_all,
  input  logic [CPU_W-1:0]                    cpu,
  input  grp_e                                grp,
  input  logic [IDX_W-1:0]                    idx,
  input  logic                                hit,
  output logic [31:0]                         rdata
);

  logic [NUM_LINES-1:0] cpu_mask;

  always_comb begin
    cpu_mask = '1;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (int'(cpu) == c) cpu_mask = mask_all[c];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr && hit) begin
      unique case (grp)
        GRP_STAT:         rdata = lines[int'(idx)*32 +: 32];
        GRP_SET, GRP_CLR: rdata = cpu_mask[int'(idx)*32 +: 32];
        default:          rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int NUM_CPUS  = 2,
  localparam int WORDS    = NUM_LINES / 32,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CPU_W    = cpu_bits(NUM_CPUS),
  localparam int ADDR_W   = CPU_W + win_lsb(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CPUS-1:0]  cpu_irq
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  logic [CPU_W-1:0] dec_cpu;
  grp_e             dec_grp;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_hit;
  logic             wr_go;

  irqagg_decode #(.NUM_CPUS(NUM_CPUS), .WORDS(WORDS)) u_dec (
    .addr (bus_addr),
    .cpu  (dec_cpu),
    .grp  (dec_grp),
    .idx  (dec_idx),
    .hit  (dec_hit)
  );

  assign wr_go = bus_sel && bus_wr && dec_hit;

  logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_all;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic sel_me;
    assign sel_me = wr_go && (int'(dec_cpu) == c);

    irqagg_mask_bank #(.NUM_LINES(NUM_LINES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .lines  (irq_lines),
      .set_en (sel_me && (dec_grp == GRP_SET)),
      .clr_en (sel_me && (dec_grp == GRP_CLR)),
      .idx    (dec_idx),
      .wdata  (bus_wdata),
      .mask   (mask_all[c]),
      .irq    (cpu_irq[c])
    );
  end

  irqagg_rdmux #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_rd (
    .sel      (bus_sel),
    .wr       (bus_wr),
    .lines    (irq_lines),
    .mask_all (mask_all),
    .cpu      (dec_cpu),
    .grp      (dec_grp),
    .idx      (dec_idx),
    .hit      (dec_hit),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int NUM_CPUS  = 2,
  localparam int WORDS    = NUM_LINES / 32,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CPU_W    = cpu_bits(NUM_CPUS)
) (
  input logic                               clk,
  input logic                               rst_s_n,
  input logic [NUM_LINES-1:0]               irq_lines,
  input logic [NUM_CPUS-1:0]                cpu_irq,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_all,
  input logic                               bus_sel,
  input logic                               bus_wr,
  input logic [31:0]                        bus_wdata,
  input logic [31:0]                        bus_rdata,
  input logic [CPU_W-1:0]                   dec_cpu,
  input grp_e                               dec_grp,
  input logic [IDX_W-1:0]                   dec_idx,
  input logic                               dec_hit
);

  // R9
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_sel && !bus_wr && !dec_hit) |-> (bus_rdata == '0));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      cpu_irq[c] == $past(|(irq_lines & ~mask_all[c])));

    // R3
    set_masks_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (bus_sel && bus_wr && dec_hit && dec_grp == GRP_SET && int'(dec_cpu) == c)
      |=> ((mask_all[c][int'($past(dec_idx))*32 +: 32] & $past(bus_wdata)) == $past(bus_wdata)));

    // R4
    clr_unmasks_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (bus_sel && bus_wr && dec_hit && dec_grp == GRP_CLR && int'(dec_cpu) == c)
      |=> ((mask_all[c][int'($past(dec_idx))*32 +: 32] & $past(bus_wdata)) == '0));

    // R7
    other_cpu_stable_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (bus_sel && bus_wr && int'(dec_cpu) != c) |=> $stable(mask_all[c]));

    // R8
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (bus_sel && bus_wr && dec_grp == GRP_STAT) |=> $stable(mask_all[c]));
  end

endmodule

bind irqagg_top irqagg_chk #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .irq_lines (irq_lines),
  .cpu_irq   (cpu_irq),
  .mask_all  (mask_all),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .dec_cpu   (dec_cpu),
  .dec_grp   (dec_grp),
  .dec_idx   (dec_idx),
  .dec_hit   (dec_hit)
);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL    = 128;
  localparam int NC    = 2;
  localparam int W     = NL / 32;
  localparam int S     = 64;
  localparam int AW    = 7;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] irq_lines;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NC-1:0] cpu_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [NL-1:0] mdl_mask [NC];

  irqagg_top #(.NUM_LINES(NL), .NUM_CPUS(NC)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int cpu, input int off);
    return AW'(cpu * S + off * 4);
  endfunction

  function automatic logic [31:0] exp_read(input int cpu, input int off);
    if (off < W)      return irq_lines[off*32 +: 32];
    if (off < 2*W)    return mdl_mask[cpu][(off-W)*32 +: 32];
    if (off < 3*W)    return mdl_mask[cpu][(off-2*W)*32 +: 32];
    return 32'h0;
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = |(irq_lines & ~mdl_mask[c]);
    return r;
  endfunction

  task automatic bus_write(input int cpu, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = mk_addr(cpu, off); bus_wdata = d;
    @(posedge clk);
    if (off >= W && off < 2*W)      mdl_mask[cpu][(off-W)*32 +: 32] |= d;
    else if (off >= 2*W && off < 3*W) mdl_mask[cpu][(off-2*W)*32 +: 32] &= ~d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input int cpu, input int off);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = mk_addr(cpu, off);
    #1;
    check(req, bus_rdata, exp_read(cpu, off));
    bus_sel = 1'b0;
  endtask

  // irq reflects state of the previous edge: wait one edge, sample at negedge
  task automatic irq_chk(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    @(negedge clk);
    irq_lines = v;
  endtask

  function automatic logic [NL-1:0] rnd_lines();
    logic [NL-1:0] v;
    for (int k = 0; k < W; k++) v[k*32 +: 32] = $urandom & $urandom & $urandom;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1; irq_lines = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int c = 0; c < NC; c++) mdl_mask[c] = '1;
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    irq_lines = '1;
    irq_chk("R1 irq low after reset");
    for (int c = 0; c < NC; c++)
      for (int k = W; k < 3*W; k++) read_chk("R1 mask all ones", c, k);

    // R2: raw status regardless of mask
    set_lines(rnd_lines());
    for (int k = 0; k < W; k++) read_chk("R2 status raw", 1, k);

    // R10: line 37 is word 1 bit 5; unmask on CPU0 only
    set_lines(NL'(1) << 37);
    bus_write(0, 2*W + 1, 32'h0000_0020);
    irq_chk("R10 line 37 routed to cpu0 only");
    check("R10 cpu1 quiet", 32'(cpu_irq[1]), 32'h0);

    // R7: CPU1 mask untouched by CPU0 write
    read_chk("R7 cpu1 mask unchanged", 1, W + 1);

    // R3: zero bits leave mask alone; one bits mask
    bus_write(0, W + 1, 32'h0);
    read_chk("R3 zero write no change", 0, W + 1);
    bus_write(0, W + 1, 32'h0000_0020);
    irq_chk("R3 masked line drops irq");
    read_chk("R5 set word readback", 0, W + 1);

    // R4: clear with ones, zeros unchanged
    bus_write(1, 2*W, 32'hF0F0_0000);
    read_chk("R4 clear partial", 1, 2*W);
    read_chk("R5 clear word readback", 1, W);

    // R8: status write ignored
    bus_write(1, 0, 32'hFFFF_FFFF);
    read_chk("R8 mask unchanged by status write", 1, W);

    // R9: out of range offsets and unselected read
    bus_write(0, 3*W, 32'hFFFF_FFFF);
    read_chk("R9 oob read zero", 0, 3*W);
    read_chk("R9 oob read zero top", 1, 15);
    read_chk("R9 oob write no effect", 0, 2*W + 1);
    @(negedge clk); bus_sel = 1'b0; bus_addr = mk_addr(0, 0); #1;
    check("R9 unselected read zero", bus_rdata, 32'h0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      int cpu;
      int off;
      op  = $urandom % 4;
      cpu = $urandom % NC;
      off = $urandom % 16;
      case (op)
        0: set_lines(rnd_lines());
        1: bus_write(cpu, W + ($urandom % W), $urandom & $urandom);
        2: bus_write(cpu, 2*W + ($urandom % W), $urandom);
        default: bus_write(cpu, off, $urandom);
      endcase
      irq_chk("R6 irq vs model");
      read_chk("R5 R2 R9 random read", $urandom % NC, $urandom % 16);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule